// File: doc/BRIEF.md
# Scheduled Mesh Tile Switch

This block is the switching interface of a single tile in a two-dimensional mesh. It has five ports: four neighbour directions (north, south, east, west) and the tile's own core. Each port has a streaming input and a streaming output. The block does not look at packet headers and has no arbitration. Instead, a program counter steps through a small local schedule memory, one entry per clock cycle. Each entry states, for every output, which input feeds it during that cycle.

Because the schedule is computed ahead of time, every transfer has a fixed and known latency. One input may feed several outputs in the same cycle. The schedule is written through a plain address/data port while a load strobe is held high. The program starts at entry 0 on the first cycle after the strobe drops, and it repeats after a programmable last entry.

The streams carry a valid flag but no ready. Back-pressure is not supported: the offline schedule guarantees that every sink accepts whatever it is sent in the cycle it arrives. A valid flag that is low means the word is a bubble.

Top module: `tile_router`

## Requirements
- R1: After reset every output valid is low, every output data is zero, the program counter is 0, and every schedule entry reads as idle on all outputs.
- R2: While `load_en` is high, `load_word` is written into the schedule entry at `load_addr` on each clock edge. The program counter is held at 0, and in the following cycle every output valid is low and every output data is zero.
- R3: On the first cycle with `load_en` low, entry 0 is used for routing. The routed word appears on the outputs one clock edge later, so the latency is one cycle from the fetch of a schedule entry.
- R4: A schedule entry is 15 bits wide. Bits [3o+2:3o] select the source for output o, with output indices north=0, south=1, east=2, west=3, core=4. Source codes 0 to 4 name the input with the same index.
- R5: Source code 7 means idle. Codes 5 and 6 are treated as idle too. An idle output has valid low and data zero.
- R6: A field that selects the output's own index as its source is treated as idle for that output.
- R7: One input may be selected by several outputs in the same entry, and each of those outputs receives the input's valid and data.
- R8: When not loading, the program counter goes up by one each cycle. When it is at or above `last_idx`, it returns to 0 on the next cycle instead.
- R9: A routed output's valid equals the selected input's valid. Its data equals the selected input's data when that valid is high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Schedule load strobe; holds the program counter at 0 |
| load_addr | input | 4 | Schedule entry written while loading |
| load_word | input | 15 | Schedule entry value (five 3-bit source fields) |
| last_idx | input | 4 | Last schedule entry before wrap-around |
| in_valid | input | 5 | Input valid flags, bit p for port p |
| in_data | input | 80 | Input data, port p in bits [16p+15:16p] |
| out_valid | output | 5 | Output valid flags, bit o for output o |
| out_data | output | 80 | Output data, output o in bits [16o+15:16o] |

## Verification
Directed entries are used to separate the cases. A permutation entry, where each output takes a different input, exposes swapped or misaligned fields. A broadcast entry, where one input feeds four outputs, checks that one source can drive several sinks. Entries holding self-selects and the codes 5, 6 and 7 must produce bubbles. Short programs with a small last entry, and a change of `last_idx` while the program runs, show whether the program counter wraps and steps correctly. Finally, a randomly filled schedule with random valid patterns and random data is run for several hundred cycles and compared with a cycle model built from the field encoding. Any error in the one-cycle latency or in the restart at entry 0 shows up as a mismatch in that comparison.

// File: rtl/tile_router_pkg.sv
package tile_router_pkg;
  localparam int NPORT   = 5;
  localparam int SELW    = 3;
  localparam int WORDW   = NPORT * SELW;
  localparam logic [SELW-1:0] SEL_IDLE = 3'd7;
endpackage

// File: rtl/sched_mem.sv
module sched_mem
  import tile_router_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [AW-1:0]    load_addr,
  input  logic [WORDW-1:0] load_word,
  input  logic [AW-1:0]    last_idx,
  output logic [AW-1:0]    pc,
  output logic [WORDW-1:0] cur_word
);
  logic [WORDW-1:0] entries [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entries[i] <= '1;
    end else if (load_en) begin
      entries[load_addr] <= load_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pc <= '0;
    else if (load_en)         pc <= '0;
    else if (pc >= last_idx)  pc <= '0;
    else                      pc <= pc + AW'(1);
  end

  assign cur_word = entries[pc];
endmodule

// File: rtl/cfg_decoder.sv
module cfg_decoder
  import tile_router_pkg::*;
(
  input  logic [WORDW-1:0]           word,
  output logic [NPORT-1:0][SELW-1:0] sel,
  output logic [NPORT-1:0]           en
);
  for (genvar o = 0; o < NPORT; o++) begin : g_field
    logic [SELW-1:0] field;
    assign field  = word[o*SELW +: SELW];
    assign en[o]  = (field < SELW'(NPORT)) && (field != SELW'(o));
    assign sel[o] = en[o] ? field : SEL_IDLE;
  end
endmodule

// File: rtl/xbar_out.sv
module xbar_out
  import tile_router_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                en,
  input  logic [SELW-1:0]     sel,
  input  logic [NPORT-1:0]    in_valid,
  input  logic [NPORT*DW-1:0] in_data,
  output logic                out_valid,
  output logic [DW-1:0]       out_data
);
  logic [SELW-1:0] idx;
  logic            nxt_valid;
  logic [DW-1:0]   nxt_data;

  always_comb begin
    idx       = en ? sel : '0;
    nxt_valid = 1'b0;
    nxt_data  = '0;
    if (en && !flush) begin
      nxt_valid = in_valid[idx];
      nxt_data  = in_valid[idx] ? in_data[idx*DW +: DW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= nxt_valid;
      out_data  <= nxt_data;
    end
  end
endmodule

// File: rtl/tile_router.sv
module tile_router
  import tile_router_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [AW-1:0]       load_addr,
  input  logic [WORDW-1:0]    load_word,
  input  logic [AW-1:0]       last_idx,
  input  logic [NPORT-1:0]    in_valid,
  input  logic [NPORT*DW-1:0] in_data,
  output logic [NPORT-1:0]    out_valid,
  output logic [NPORT*DW-1:0] out_data
);
  logic [AW-1:0]             pc;
  logic [WORDW-1:0]          cur_word;
  logic [NPORT-1:0][SELW-1:0] sel;
  logic [NPORT-1:0]          en;

  sched_mem #(.DEPTH(DEPTH)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_word (load_word),
    .last_idx  (last_idx),
    .pc        (pc),
    .cur_word  (cur_word)
  );

  cfg_decoder u_dec (
    .word (cur_word),
    .sel  (sel),
    .en   (en)
  );

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xbar_out #(.DW(DW)) u_xo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (load_en),
      .en        (en[o]),
      .sel       (sel[o]),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o*DW +: DW])
    );
  end
endmodule

// File: rtl/tile_router_checker.sv
module tile_router_checker
  import tile_router_pkg::*;
#(
  parameter int AW = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      load_en,
  input logic [AW-1:0]             last_idx,
  input logic [AW-1:0]             pc,
  input logic [NPORT-1:0]          in_valid,
  input logic [NPORT-1:0]          out_valid,
  input logic [NPORT-1:0][SELW-1:0] sel,
  input logic [NPORT-1:0]          en
);
  p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (out_valid == '0));

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (pc == '0));

  p_pc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && pc >= last_idx) |=> (pc == '0));

  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && pc < last_idx) |=> (pc == AW'($past(pc) + 1'b1)));

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    p_idle_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en[o] |=> !out_valid[o]);

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && en[o]) |=> (out_valid[o] == $past(in_valid[sel[o]])));
  end
endmodule

bind tile_router tile_router_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_en   (load_en),
  .last_idx  (last_idx),
  .pc        (pc),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .sel       (sel),
  .en        (en)
);

// File: tb/tile_router_bench.sv
`timescale 1ns/1ps
module tile_router_bench;
  localparam int NP = 5;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load_en = 1'b0;
  logic [3:0]      load_addr = '0;
  logic [14:0]     load_word = '0;
  logic [3:0]      last_idx = 4'd15;
  logic [NP-1:0]   in_valid = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0]   out_valid;
  logic [NP*DW-1:0] out_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [14:0]      sched [16];
  int               pc_m = 0;
  logic [NP-1:0]    exp_v = '0;
  logic [NP*DW-1:0] exp_d = '0;
  bit               have_exp = 1'b0;
  string            exp_tag = "R1";

  always #2.5 clk = ~clk;

  tile_router u_tile_router (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_word(load_word), .last_idx(last_idx), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [14:0] mk(int n, int s, int e, int w, int c);
    return {3'(c), 3'(w), 3'(e), 3'(s), 3'(n)};
  endfunction

  // One clock cycle: check the previous expectation, drive new inputs,
  // compute what the outputs must show after this edge.
  task automatic step(input bit ld, input logic [3:0] addr,
                      input logic [14:0] word, input string tag);
    @(negedge clk);
    if (have_exp) begin
      for (int o = 0; o < NP; o++) begin
        tests++;
        if (out_valid[o] !== exp_v[o] || out_data[o*DW +: DW] !== exp_d[o*DW +: DW]) begin
          fails++;
          $display("FAIL %s out%0d got v=%b d=%h exp v=%b d=%h", exp_tag, o,
                   out_valid[o], out_data[o*DW +: DW], exp_v[o], exp_d[o*DW +: DW]);
        end
      end
    end
    load_en   = ld;
    load_addr = addr;
    load_word = word;
    for (int p = 0; p < NP; p++) begin
      in_valid[p] = ($urandom_range(3) != 0);
      in_data[p*DW +: DW] = 16'($urandom);
    end
    exp_v = '0;
    exp_d = '0;
    if (ld) begin
      sched[addr] = word;
      pc_m = 0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        int f;
        f = int'(sched[pc_m][o*3 +: 3]);
        if (f < NP && f != o) begin
          exp_v[o] = in_valid[f];
          exp_d[o*DW +: DW] = in_valid[f] ? in_data[f*DW +: DW] : '0;
        end
      end
      pc_m = (pc_m >= int'(last_idx)) ? 0 : pc_m + 1;
    end
    exp_tag  = tag;
    have_exp = 1'b1;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 15'd0, tag);
  endtask

  task automatic load_prog(input int n, input logic [14:0] w0, input logic [14:0] w1,
                           input logic [14:0] w2);
    step(1'b1, 4'd0, w0, "R2");
    if (n > 1) step(1'b1, 4'd1, w1, "R2");
    if (n > 2) step(1'b1, 4'd2, w2, "R2");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      done = 1'b1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) sched[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    have_exp = 1'b1;  // R1: reset state is all zero
    exp_tag = "R1";
    run(6, "R1");     // R1: all entries idle after reset

    // R4: permutation N<-S, S<-E, E<-W, W<-core, core<-N; R3 first entry
    last_idx = 4'd0;
    load_prog(1, mk(1, 2, 3, 4, 0), '0, '0);
    step(1'b0, 4'd0, 15'd0, "R3");
    run(5, "R4");

    // R7: broadcast of north to four outputs, north output idle
    load_prog(1, mk(7, 0, 0, 0, 0), '0, '0);
    run(6, "R7");

    // R6 self-selects, R5 codes 5/6/7, alternated with a legal entry (R8 wrap at 2)
    last_idx = 4'd2;
    load_prog(3, mk(0, 1, 2, 3, 4), mk(5, 6, 7, 5, 6), mk(4, 3, 1, 2, 0));
    run(9, "R6");
    run(3, "R5");

    // R8: change last_idx while running
    for (int i = 3; i < 16; i++) step(1'b1, 4'(i), mk(i % 5, (i + 1) % 5, (i + 2) % 5, 7, (i + 3) % 5), "R2");
    last_idx = 4'd15;
    run(20, "R8");
    last_idx = 4'd4;
    run(12, "R8");
    last_idx = 4'd0;
    run(4, "R8");

    // R2: reload mid-run, then R9 random schedules
    for (int round = 0; round < 4; round++) begin
      for (int a = 0; a < 16; a++)
        step(1'b1, 4'(a), 15'($urandom), "R2");
      last_idx = 4'($urandom_range(15));
      step(1'b0, 4'd0, 15'd0, "R3");
      run(150, "R9");
    end

    @(negedge clk);
    for (int o = 0; o < NP; o++) begin
      tests++;
      if (out_valid[o] !== exp_v[o] || out_data[o*DW +: DW] !== exp_d[o*DW +: DW]) begin
        fails++;
        $display("FAIL %s out%0d got v=%b d=%h exp v=%b d=%h", exp_tag, o,
                 out_valid[o], out_data[o*DW +: DW], exp_v[o], exp_d[o*DW +: DW]);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule